// File: doc/BRIEF.md
# Capture Clock Sequencer for Shared Scan Domains

This block drives the scan-enable line and the gated clocks of several scan clock domains that share one scan-enable during test. While scan-enable is high, a shift request pulses every domain together. When a capture window is started, scan-enable drops. Then each domain whose bit is set in a serially loaded enable mask gets exactly one capture pulse. The pulses come in ascending domain order, with programmable idle gaps before the first pulse, between pulses, and after the last pulse. Scan-enable then rises again.

Setting every mask bit gives a staggered capture across all domains in the fixed order. Setting a single bit gives a one-hot capture of that domain. Every core that shares these clocks sees the same order. Each domain clock is gated through a latch that is transparent while the base clock is low, so an output only ever carries whole base-clock high phases.

Top module: `cap_clk_sequencer`

## Requirements
- R1: After reset, scan_en is high, done is low, no domain clock pulses, and the enable mask is all zeros, so a capture window started without loading the mask produces no capture pulse.
- R2: A cap_start sampled high at a rising base-clock edge while idle makes scan_en low from that same edge.
- R3: The mask is loaded serially: each edge with cfg_shift high while idle shifts cfg_si in from the top. After N_DOM shifts, the first bit shifted sits at domain 0 and the last at domain N_DOM-1. A bit of 1 means that domain captures. Capture pulses are issued in ascending domain index.
- R4: Strictly between the edge where scan_en falls and the first capture edge there are exactly max(lead_cyc,1) base-clock rising edges.
- R5: Each domain with its mask bit set gets exactly one capture pulse and the others get none. Masked domains leave no slot: between two consecutive capture edges there are exactly max(gap_cyc,1) base-clock rising edges. At most one domain clock is active at a time while scan_en is low.
- R6: Strictly between the last capture edge and the edge where scan_en rises there are max(trail_cyc,1) rising edges. With an empty mask, there are max(lead_cyc,1)+max(trail_cyc,1) edges between the fall and the rise.
- R7: done is high for exactly the one cycle that starts at the edge where scan_en rises.
- R8: While idle, a shift_en sampled high at edge t makes every domain clock pulse at edge t+1 and not at edge t. A low shift_en gives no pulse.
- R9: During a capture window, cfg_shift, cfg_si, cap_start and changes of the three delay inputs have no effect on the running window, on the stored mask or on what happens after it.
- R10: A domain clock is never high while the base clock is low; each pulse coincides with a whole base-clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Shift one mask bit in while idle |
| cfg_si | input | 1 | Serial mask bit |
| shift_en | input | 1 | Request one shift pulse on all domains while idle |
| cap_start | input | 1 | Start a capture window while idle |
| lead_cyc | input | CNT_W | Idle edges before the first capture pulse (0 treated as 1) |
| gap_cyc | input | CNT_W | Idle edges between capture pulses (0 treated as 1) |
| trail_cyc | input | CNT_W | Idle edges after the last capture pulse (0 treated as 1) |
| scan_en | output | 1 | Global scan-enable, high in shift, low in capture |
| dom_clk | output | N_DOM | Gated domain clocks |
| done | output | 1 | One-cycle flag when the capture window closes |

## Verification
The sequencer is tried with a full mask, which gives the staggered order. It is also tried with single-bit masks at both ends of the index range, which separate a one-hot capture from an ordering fault, and with sparse masks such as 0101, which expose any empty slot left for a masked domain. An empty mask straight after reset shows that the reset mask is clear and that lead and trail add up. Delays of zero exercise the minimum clamp. Random masks and delays from a fixed seed cover the rest. Some windows are disturbed by mask shifts, restarts and delay changes mid-window, then repeated without reloading, which shows that the mask and the latched delays are frozen.

// File: rtl/cap_seq_pkg.sv
package cap_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2,
        ST_DONE  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/cs_pick_first.sv
module cs_pick_first #(
    parameter int N_DOM = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_DOM-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = N_DOM - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/cs_clk_gate.sv
module cs_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_l;

    // transparent only while the base clock is low
    always_latch begin
        if (!clk) en_l = en;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/cap_clk_sequencer.sv
module cap_clk_sequencer
    import cap_seq_pkg::*;
#(
    parameter int N_DOM = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift,
    input  logic             cfg_si,
    input  logic             shift_en,
    input  logic             cap_start,
    input  logic [CNT_W-1:0] lead_cyc,
    input  logic [CNT_W-1:0] gap_cyc,
    input  logic [CNT_W-1:0] trail_cyc,
    output logic             scan_en,
    output logic [N_DOM-1:0] dom_clk,
    output logic             done
);
    localparam int IDX_W = (N_DOM > 1) ? $clog2(N_DOM) : 1;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [N_DOM-1:0] pend;
        logic [IDX_W-1:0] dom;
        logic             tail;
        logic [CNT_W-1:0] gap;
        logic [CNT_W-1:0] trail;
        logic [N_DOM-1:0] msk;
        logic             shift;
    } seq_s;

    seq_s q, d;

    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;
    logic [N_DOM-1:0] gate_en;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    cs_pick_first #(.N_DOM(N_DOM), .IDX_W(IDX_W)) u_pick (
        .vec (q.pend),
        .idx (pick_idx),
        .any (pick_any)
    );

    always_comb begin
        d       = q;
        d.shift = shift_en;
        unique case (q.st)
            ST_IDLE: begin
                if (cfg_shift) d.msk = {cfg_si, q.msk[N_DOM-1:1]};
                if (cap_start) begin
                    d.st    = ST_WAIT;
                    d.cnt   = at_least_one(lead_cyc) - 1'b1;
                    d.pend  = q.msk;
                    d.gap   = at_least_one(gap_cyc);
                    d.trail = at_least_one(trail_cyc);
                    d.tail  = 1'b0;
                end
            end
            ST_WAIT: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.tail) begin
                    d.st = ST_DONE;
                end else if (pick_any) begin
                    d.st             = ST_PULSE;
                    d.dom            = pick_idx;
                    d.pend[pick_idx] = 1'b0;
                end else begin
                    d.tail = 1'b1;
                    d.cnt  = q.trail;
                end
            end
            ST_PULSE: begin
                d.st = ST_WAIT;
                if (|q.pend) begin
                    d.cnt  = q.gap - 1'b1;
                    d.tail = 1'b0;
                end else begin
                    d.cnt  = q.trail;
                    d.tail = 1'b1;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        gate_en = '0;
        if (q.st == ST_IDLE && q.shift) gate_en = '1;
        else if (q.st == ST_PULSE)      gate_en[q.dom] = 1'b1;
    end

    for (genvar g = 0; g < N_DOM; g++) begin : g_gate
        cs_clk_gate u_gate (
            .clk  (clk),
            .en   (gate_en[g]),
            .gclk (dom_clk[g])
        );
    end

    assign scan_en = (q.st == ST_IDLE) || (q.st == ST_DONE);
    assign done    = (q.st == ST_DONE);

    AST_START_DROPS_SE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && cap_start) |=> !scan_en); // R2
    AST_ONE_DOMAIN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> $onehot0(gate_en)); // R5
    AST_PULSED_BIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PULSE) |-> !q.pend[q.dom]); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_ON_SE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en) |-> done); // R7
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> $stable(q.msk)); // R9
endmodule

// File: tb/cap_clk_sequencer_tb.sv
`timescale 1ns/1ps
module cap_clk_sequencer_tb;
    localparam int N  = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_shift = 1'b0, cfg_si = 1'b0, shift_en = 1'b0, cap_start = 1'b0;
    logic [CW-1:0] lead_cyc = '0, gap_cyc = '0, trail_cyc = '0;
    logic          scan_en, done;
    logic [N-1:0]  dom_clk;

    int  n_chk = 0, n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    cap_clk_sequencer #(.N_DOM(N), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_si(cfg_si),
        .shift_en(shift_en), .cap_start(cap_start), .lead_cyc(lead_cyc),
        .gap_cyc(gap_cyc), .trail_cyc(trail_cyc), .scan_en(scan_en),
        .dom_clk(dom_clk), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic load_mask(input logic [N-1:0] m);
        for (int i = 0; i < N; i++) begin
            @(negedge clk); cfg_shift = 1'b1; cfg_si = m[i];
        end
        @(negedge clk); cfg_shift = 1'b0; cfg_si = 1'b0;
    endtask

    // R3 R4 R5 R6 R7 R9 R10: one capture window, measured in base-clock edges from the fall
    task automatic run_window(input logic [N-1:0] m, input int L, input int G, input int T, input bit disturb);
        int got_k[N];
        int got_n[N];
        int exp_k[N];
        int rise_k = -1, done_k = -1, done_n = 0, low_bad = 0, c = 0, exp_rise;
        bit first = 1'b1;
        for (int i = 0; i < N; i++) begin got_k[i] = -1; got_n[i] = 0; exp_k[i] = -1; end
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                c = first ? clampv(L) + 1 : c + clampv(G) + 1;
                exp_k[i] = c;
                first = 1'b0;
            end
        end
        exp_rise = first ? clampv(L) + clampv(T) + 1 : c + clampv(T) + 1;

        @(negedge clk);
        lead_cyc = CW'(L); gap_cyc = CW'(G); trail_cyc = CW'(T); cap_start = 1'b1;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk); #1;
            if (k == 0) begin
                cap_start = 1'b0;
                chk(scan_en == 1'b0, "R2", "scan_en after start", int'(scan_en), 0);
            end
            for (int i = 0; i < N; i++) begin
                if (dom_clk[i]) begin got_n[i]++; got_k[i] = k; end
            end
            if (done) begin done_n++; done_k = k; end
            #2;
            if (dom_clk != '0) low_bad++;
            if (disturb && k == 1) begin
                cfg_shift = 1'b1; cfg_si = ~m[0]; cap_start = 1'b1;
                gap_cyc = '0; trail_cyc = CW'(9); lead_cyc = CW'(7);
            end
            if (disturb && k == 2) begin
                cfg_shift = 1'b0; cap_start = 1'b0;
            end
            if (k > 0 && scan_en) begin rise_k = k; break; end
        end
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                chk(got_n[i] == 1, "R5", $sformatf("pulses on domain %0d", i), got_n[i], 1);
                chk(got_k[i] == exp_k[i], (exp_k[i] == clampv(L) + 1) ? "R4" : "R5",
                    $sformatf("capture edge of domain %0d", i), got_k[i], exp_k[i]);
            end else begin
                chk(got_n[i] == 0, "R3", $sformatf("masked domain %0d pulses", i), got_n[i], 0);
            end
        end
        chk(rise_k == exp_rise, "R6", "scan_en rise edge", rise_k, exp_rise);
        chk(done_n == 1 && done_k == rise_k, "R7", "done edge", done_k, rise_k);
        chk(low_bad == 0, "R10", "domain clock high in low phase", low_bad, 0);
        @(posedge clk); #1;
        chk(done == 1'b0, "R7", "done after one cycle", int'(done), 0);
        chk(scan_en == 1'b1, "R9", "no restart after window", int'(scan_en), 1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        finished = 1'b1;
        $finish;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        logic [N-1:0] m;
        void'($urandom(32'd1500));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk(scan_en == 1'b1, "R1", "scan_en after reset", int'(scan_en), 1);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(dom_clk == '0, "R1", "domain clocks after reset", int'(dom_clk), 0);

        // R1 R6: reset mask is empty
        run_window('0, 2, 1, 3, 1'b0);

        // R8: single shift pulse on all domains
        @(negedge clk) shift_en = 1'b1;
        @(posedge clk); #1;
        chk(dom_clk == '0, "R8", "no pulse at sampling edge", int'(dom_clk), 0);
        #2 shift_en = 1'b0;
        @(posedge clk); #1;
        chk(dom_clk == '1, "R8", "shift pulse on all", int'(dom_clk), (1 << N) - 1);
        @(posedge clk); #1;
        chk(dom_clk == '0, "R8", "no pulse with shift_en low", int'(dom_clk), 0);

        // R3 R5: staggered, one-hot at both ends, sparse
        load_mask(4'b1111); run_window(4'b1111, 2, 3, 2, 1'b0);
        load_mask(4'b0001); run_window(4'b0001, 1, 1, 1, 1'b0);
        load_mask(4'b1000); run_window(4'b1000, 3, 2, 4, 1'b0);
        load_mask(4'b0101); run_window(4'b0101, 0, 0, 0, 1'b0);

        // R9: disturbed window, then repeat without reloading
        load_mask(4'b1010); run_window(4'b1010, 2, 2, 2, 1'b1);
        run_window(4'b1010, 1, 3, 1, 1'b0);

        for (int r = 0; r < 25; r++) begin
            m = N'($urandom_range(0, (1 << N) - 1));
            load_mask(m);
            run_window(m, $urandom_range(0, 6), $urandom_range(0, 6),
                       $urandom_range(0, 6), 1'($urandom_range(0, 1)));
        end
        finish_run();
    end
endmodule